// File: doc/BRIEF.md
# Program Counter Sequencer with Byte-Wide RAM Stack

This block owns the 15-bit program counter of a small 8-bit controller and drives the instruction fetch address. The counter is kept as a 7-bit upper half and an 8-bit lower half. The block advances the counter by one, loads a jump target, enters a subroutine or an interrupt, and returns from either. Return addresses are kept as single bytes in data RAM, addressed by a stack pointer that the block holds itself. The pointer starts at 0x6F, moves down on each push and always names the next free byte.

A call or an interrupt stores the low byte and then the high byte of the return address, one byte per cycle. A return reads them back high byte first and rebuilds the counter. Every interrupt lands on the one shared vector 0x00FF. A return issued while the stack is empty makes no RAM access and sends the counter to the top address 0x7FFF. The fetch path zero-fills that location and anything beyond the programmed range. A fetched zero byte is flagged as the software-trap opcode, so such a return ends in a trap.

The block takes one command at a time. It raises `busy` for the extra cycles that a stack transfer needs, and ignores commands while `busy` is high.

Top module: `pcseq_top`

## Requirements
- R1: While reset is held and just after it, the fetch address is 0x0000, the stack pointer is 0x6F, `busy` is low, and neither `ramWe` nor `ramRe` is high.
- R2: A step command (code 1) accepted on an edge makes the fetch address one higher after that edge, wrapping from 0x7FFF to 0x0000.
- R3: A jump command (code 2) loads `cmdTarget` into the fetch address on the accepting edge.
- R4: A call command (code 3) takes two push cycles with `busy` high. In the first, `ramAddr` is SP and `ramWdata` is bits 7:0 of the address after the current one. In the second, `ramAddr` is SP-1 and `ramWdata` is bits 14:8 of that address with bit 7 zero. After the second cycle the counter equals `cmdTarget`, SP has dropped by 2, and `busy` is low.
- R5: An interrupt command (code 5) pushes exactly as in R4, but the pushed value is the current counter. The counter then becomes 0x00FF.
- R6: A return command (code 4) with SP not equal to 0x6F reads at SP+1 (upper half) and then at SP+2 (lower half), with read data due one cycle after each read strobe. `busy` is high for three cycles, and the counter is rebuilt three edges after acceptance. SP ends 2 higher.
- R7: A return command with SP equal to 0x6F sets the counter to 0x7FFF on the accepting edge. It makes no RAM read or write, leaves SP unchanged, and keeps `busy` low.
- R8: Commands presented while `busy` is high, and command codes 0, 6 and 7, leave the counter and SP unchanged.
- R9: `progWord` equals `progData` when the counter is at most 0x7FFE and is 0x00 at 0x7FFF. `trapHit` is high exactly when `progWord` is 0x00.
- R10: `ramWe` and `ramRe` are never high together, and neither is high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present this cycle |
| cmdOp | input | 3 | Command code: 0 none, 1 step, 2 jump, 3 call, 4 return, 5 interrupt |
| cmdTarget | input | 15 | Jump or call destination |
| busy | output | 1 | Stack transfer in progress; commands ignored |
| fetchAddr | output | 15 | Current program counter |
| progData | input | 8 | Byte read from program memory at `fetchAddr` |
| progWord | output | 8 | Fetched byte after zero-fill of the top location |
| trapHit | output | 1 | Fetched byte is the software-trap opcode 0x00 |
| ramWe | output | 1 | Stack write strobe |
| ramRe | output | 1 | Stack read strobe; data expected next cycle |
| ramAddr | output | 8 | Stack byte address |
| ramWdata | output | 8 | Stack write byte |
| ramRdata | input | 8 | Stack read byte, one cycle after `ramRe` |
| spOut | output | 8 | Current stack pointer |

## Verification
Step, jump and empty-stack return change the counter on the accepting edge itself. Calls and interrupts show their two writes in the two cycles after acceptance and the new counter after the second. Non-empty returns show their reads in the first two cycles and the rebuilt counter after the third. The bench drives each command half a cycle before its accepting edge and samples at each following falling edge, checking the strobes or counter that are due in exactly that cycle. The fetch word and trap flag are combinational from the counter, so they are checked in the same sample as the counter they belong to.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_STEP = 3'd1,
    OP_JUMP = 3'd2,
    OP_CALL = 3'd3,
    OP_RET  = 3'd4,
    OP_IRQ  = 3'd5
  } seqOp_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic stepPc;
    logic jumpPc;
    logic forceTop;
    logic capCall;
    logic capIrq;
    logic pushLo;
    logic pushHi;
    logic popHi;
    logic popLo;
    logic popFin;
  } seqStrobe_t;

endpackage

// File: rtl/pcseq_ctrl.sv
module pcseq_ctrl
  import pcseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  input  logic       spEmpty,
  output logic       busy,
  output seqStrobe_t stb
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_LO,
    ST_PUSH_HI,
    ST_POP_HI,
    ST_POP_LO,
    ST_POP_FIN
  } seqState_e;

  seqState_e state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stb      = '0;
    stateNxt = state;
    unique case (state)
      ST_IDLE: begin
        if (cmdValid) begin
          case (cmdOp)
            OP_STEP: stb.stepPc = 1'b1;
            OP_JUMP: stb.jumpPc = 1'b1;
            OP_CALL: begin
              stb.capCall = 1'b1;
              stateNxt    = ST_PUSH_LO;
            end
            OP_IRQ: begin
              stb.capIrq = 1'b1;
              stateNxt   = ST_PUSH_LO;
            end
            OP_RET: begin
              if (spEmpty) stb.forceTop = 1'b1;
              else         stateNxt     = ST_POP_HI;
            end
            default: ;
          endcase
        end
      end
      ST_PUSH_LO: begin
        stb.pushLo = 1'b1;
        stateNxt   = ST_PUSH_HI;
      end
      ST_PUSH_HI: begin
        stb.pushHi = 1'b1;
        stateNxt   = ST_IDLE;
      end
      ST_POP_HI: begin
        stb.popHi = 1'b1;
        stateNxt  = ST_POP_LO;
      end
      ST_POP_LO: begin
        stb.popLo = 1'b1;
        stateNxt  = ST_POP_FIN;
      end
      ST_POP_FIN: begin
        stb.popFin = 1'b1;
        stateNxt   = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/pcseq_fetch.sv
module pcseq_fetch #(
  parameter int                PC_W      = 15,
  parameter int                D_W       = 8,
  parameter logic [PC_W-1:0]   PROG_LAST = 15'h7FFE
) (
  input  logic [PC_W-1:0] pc,
  input  logic [D_W-1:0]  progData,
  output logic [D_W-1:0]  progWord,
  output logic            trapHit
);

  localparam logic [D_W-1:0] TRAP_OP = '0;

  logic inRange;

  assign inRange  = (pc <= PROG_LAST);
  assign progWord = inRange ? progData : TRAP_OP;
  assign trapHit  = (progWord == TRAP_OP);

endmodule

// File: rtl/pcseq_dp.sv
module pcseq_dp
  import pcseq_pkg::*;
#(
  parameter int              PC_W     = 15,
  parameter int              LO_W     = 8,
  parameter int              D_W      = 8,
  parameter int              A_W      = 8,
  parameter logic [A_W-1:0]  SP_EMPTY = 8'h6F,
  parameter logic [PC_W-1:0] IRQ_VEC  = 15'h00FF
) (
  input  logic            clk,
  input  logic            rstN,
  input  seqStrobe_t      stb,
  input  logic [PC_W-1:0] cmdTarget,
  input  logic [D_W-1:0]  ramRdata,
  output logic [PC_W-1:0] pc,
  output logic [A_W-1:0]  sp,
  output logic            spEmpty,
  output logic            ramWe,
  output logic            ramRe,
  output logic [A_W-1:0]  ramAddr,
  output logic [D_W-1:0]  ramWdata
);

  localparam int              HI_W   = PC_W - LO_W;
  localparam logic [PC_W-1:0] PC_ONE = 1;
  localparam logic [PC_W-1:0] PC_TOP = '1;
  localparam logic [A_W-1:0]  SP_ONE = 1;

  logic [PC_W-1:0] retReg, destReg;
  logic [HI_W-1:0] hiReg;
  logic [D_W-1:0]  loByte, hiByte;
  logic [PC_W-1:0] popPc;

  always_comb begin
    loByte = '0;
    hiByte = '0;
    loByte[LO_W-1:0] = retReg[LO_W-1:0];
    hiByte[HI_W-1:0] = retReg[PC_W-1:LO_W];
  end

  assign popPc = {hiReg, ramRdata[LO_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc      <= '0;
      sp      <= SP_EMPTY;
      retReg  <= '0;
      destReg <= '0;
      hiReg   <= '0;
    end else begin
      if (stb.stepPc)        pc <= pc + PC_ONE;
      else if (stb.jumpPc)   pc <= cmdTarget;
      else if (stb.forceTop) pc <= PC_TOP;
      else if (stb.pushHi)   pc <= destReg;
      else if (stb.popFin)   pc <= popPc;

      if (stb.capCall) begin
        retReg  <= pc + PC_ONE;
        destReg <= cmdTarget;
      end else if (stb.capIrq) begin
        retReg  <= pc;
        destReg <= IRQ_VEC;
      end

      if (stb.pushLo || stb.pushHi)    sp <= sp - SP_ONE;
      else if (stb.popHi || stb.popLo) sp <= sp + SP_ONE;

      if (stb.popLo) hiReg <= ramRdata[HI_W-1:0];
    end
  end

  assign spEmpty  = (sp == SP_EMPTY);
  assign ramWe    = stb.pushLo | stb.pushHi;
  assign ramRe    = stb.popHi | stb.popLo;
  assign ramAddr  = ramRe ? (sp + SP_ONE) : sp;
  assign ramWdata = stb.pushHi ? hiByte : loByte;

endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
  import pcseq_pkg::*;
#(
  parameter int              PC_W      = 15,
  parameter int              LO_W      = 8,
  parameter int              D_W       = 8,
  parameter int              A_W       = 8,
  parameter logic [A_W-1:0]  SP_EMPTY  = 8'h6F,
  parameter logic [PC_W-1:0] IRQ_VEC   = 15'h00FF,
  parameter logic [PC_W-1:0] PROG_LAST = 15'h7FFE
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdValid,
  input  logic [2:0]      cmdOp,
  input  logic [PC_W-1:0] cmdTarget,
  output logic            busy,
  output logic [PC_W-1:0] fetchAddr,
  input  logic [D_W-1:0]  progData,
  output logic [D_W-1:0]  progWord,
  output logic            trapHit,
  output logic            ramWe,
  output logic            ramRe,
  output logic [A_W-1:0]  ramAddr,
  output logic [D_W-1:0]  ramWdata,
  input  logic [D_W-1:0]  ramRdata,
  output logic [A_W-1:0]  spOut
);

  seqStrobe_t stb;
  logic       spEmpty;

  pcseq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .spEmpty  (spEmpty),
    .busy     (busy),
    .stb      (stb)
  );

  pcseq_dp #(
    .PC_W(PC_W), .LO_W(LO_W), .D_W(D_W), .A_W(A_W),
    .SP_EMPTY(SP_EMPTY), .IRQ_VEC(IRQ_VEC)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .cmdTarget (cmdTarget),
    .ramRdata  (ramRdata),
    .pc        (fetchAddr),
    .sp        (spOut),
    .spEmpty   (spEmpty),
    .ramWe     (ramWe),
    .ramRe     (ramRe),
    .ramAddr   (ramAddr),
    .ramWdata  (ramWdata)
  );

  pcseq_fetch #(
    .PC_W(PC_W), .D_W(D_W), .PROG_LAST(PROG_LAST)
  ) u_fetch (
    .pc       (fetchAddr),
    .progData (progData),
    .progWord (progWord),
    .trapHit  (trapHit)
  );

endmodule

// File: rtl/pcseq_chk.sv
module pcseq_chk #(
  parameter int              PC_W     = 15,
  parameter int              D_W      = 8,
  parameter int              A_W      = 8,
  parameter logic [A_W-1:0]  SP_EMPTY = 8'h6F
) (
  input logic            clk,
  input logic            rstN,
  input logic            cmdValid,
  input logic [2:0]      cmdOp,
  input logic [PC_W-1:0] cmdTarget,
  input logic            busy,
  input logic [PC_W-1:0] fetchAddr,
  input logic [D_W-1:0]  progWord,
  input logic            ramWe,
  input logic            ramRe,
  input logic [A_W-1:0]  spOut
);

  localparam logic [PC_W-1:0] PC_ONE = 1;
  localparam logic [PC_W-1:0] PC_TOP = '1;
  localparam logic [A_W-1:0]  SP_ONE = 1;

  a_r10_no_rw_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(ramWe && ramRe));

  a_r10_strobes_need_busy: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!ramWe && !ramRe));

  a_r2_step_adds_one: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmdValid && cmdOp == 3'd1) |=> fetchAddr == $past(fetchAddr) + PC_ONE);

  a_r3_jump_loads: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmdValid && cmdOp == 3'd2) |=> fetchAddr == $past(cmdTarget));

  a_r7_empty_return: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmdValid && cmdOp == 3'd4 && spOut == SP_EMPTY)
      |=> (fetchAddr == PC_TOP && !busy && spOut == SP_EMPTY));

  a_r4_push_lowers_sp: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |=> spOut == $past(spOut) - SP_ONE);

  a_r6_pop_raises_sp: assert property (@(posedge clk) disable iff (!rstN)
    ramRe |=> spOut == $past(spOut) + SP_ONE);

  a_r9_top_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    fetchAddr == PC_TOP |-> progWord == '0);

endmodule

bind pcseq_top pcseq_chk #(
  .PC_W(PC_W), .D_W(D_W), .A_W(A_W), .SP_EMPTY(SP_EMPTY)
) u_chk (.*);

// File: tb/sim_pcseq_top.sv
`timescale 1ns/1ps
module sim_pcseq_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cmdValid;
  logic [2:0]  cmdOp;
  logic [14:0] cmdTarget;
  logic        busy;
  logic [14:0] fetchAddr;
  logic [7:0]  progData;
  logic [7:0]  progWord;
  logic        trapHit;
  logic        ramWe, ramRe;
  logic [7:0]  ramAddr, ramWdata, ramRdata, spOut;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pcseq_top u0 (.*);

  // stack RAM model with one-cycle read latency
  logic [7:0] ram [256];
  always @(posedge clk) begin
    if (ramWe) ram[ramAddr] <= ramWdata;
    if (ramRe) ramRdata <= ram[ramAddr];
  end

  function automatic logic [7:0] pmem(input logic [14:0] a);
    if (a[2:0] == 3'd5) return 8'h00;
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h3C;
  endfunction

  assign progData = pmem(fetchAddr);

  function automatic logic [7:0] expWord(input logic [14:0] a);
    return (a == 15'h7FFF) ? 8'h00 : pmem(a);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [14:0] expPc;
  logic [7:0]  expSp;
  logic [14:0] stk [16];
  int          depth = 0;

  task automatic checkFetch();
    check("R9 word", progWord, expWord(expPc));
    check("R9 trap", trapHit, expWord(expPc) == 8'h00);
  endtask

  task automatic simple(input logic [2:0] op, input logic [14:0] tgt);
    cmdValid = 1'b1; cmdOp = op; cmdTarget = tgt;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic doPush(input bit irq, input logic [14:0] tgt, input bit junk);
    logic [14:0] ret, dest;
    ret  = irq ? expPc : expPc + 15'd1;
    dest = irq ? 15'h00FF : tgt;
    cmdValid = 1'b1; cmdOp = irq ? 3'd5 : 3'd3; cmdTarget = tgt;
    @(negedge clk);
    cmdValid = junk; cmdOp = 3'd2; cmdTarget = 15'h1234;
    check(irq ? "R5 busy1" : "R4 busy1", busy, 1);
    check("R4 we1", ramWe, 1);
    check("R10 re1", ramRe, 0);
    check("R4 addr1", ramAddr, expSp);
    check(irq ? "R5 lo" : "R4 lo", ramWdata, ret[7:0]);
    @(negedge clk);
    check("R4 we2", ramWe, 1);
    check("R4 addr2", ramAddr, expSp - 8'd1);
    check(irq ? "R5 hi" : "R4 hi", ramWdata, {1'b0, ret[14:8]});
    @(negedge clk);
    cmdValid = 1'b0;
    expSp = expSp - 8'd2;
    expPc = dest;
    check(irq ? "R5 pc" : "R4 pc", fetchAddr, expPc);
    check("R4 sp", spOut, expSp);
    check("R4 busy0", busy, 0);
    check("R10 idle we", ramWe, 0);
    checkFetch();
    stk[depth] = ret; depth++;
  endtask

  task automatic doRet(input bit junk);
    cmdValid = 1'b1; cmdOp = 3'd4; cmdTarget = 15'h0;
    if (expSp == 8'h6F) begin
      @(negedge clk);
      cmdValid = 1'b0;
      expPc = 15'h7FFF;
      check("R7 pc", fetchAddr, expPc);
      check("R7 busy", busy, 0);
      check("R7 no re", ramRe, 0);
      check("R7 no we", ramWe, 0);
      check("R7 sp", spOut, 8'h6F);
      checkFetch();
    end else begin
      @(negedge clk);
      cmdValid = junk; cmdOp = 3'd3; cmdTarget = 15'h0555;
      check("R6 re1", ramRe, 1);
      check("R10 we1", ramWe, 0);
      check("R6 addr1", ramAddr, expSp + 8'd1);
      @(negedge clk);
      check("R6 re2", ramRe, 1);
      check("R6 addr2", ramAddr, expSp + 8'd2);
      @(negedge clk);
      check("R6 busy3", busy, 1);
      check("R8 pc held", fetchAddr, expPc);
      @(negedge clk);
      cmdValid = 1'b0;
      depth--;
      expPc = stk[depth];
      expSp = expSp + 8'd2;
      check("R6 pc", fetchAddr, expPc);
      check("R6 sp", spOut, expSp);
      check("R6 busy0", busy, 0);
      checkFetch();
    end
  endtask

  initial begin
    rstN = 1'b0; cmdValid = 1'b0; cmdOp = 3'd0; cmdTarget = '0;
    for (int i = 0; i < 256; i++) ram[i] = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 pc rst", fetchAddr, 0);
    check("R1 sp rst", spOut, 8'h6F);
    check("R1 busy rst", busy, 0);
    check("R1 strobes rst", {ramWe, ramRe}, 0);
    rstN = 1'b1;
    @(negedge clk);
    expPc = 15'h0; expSp = 8'h6F;
    check("R1 pc after", fetchAddr, 0);
    check("R1 busy after", busy, 0);

    // jump and step sweep, including the wrap at the top
    for (int i = 0; i < 300; i++) begin
      logic [14:0] t;
      t = (i == 0) ? 15'h7FFE : 15'((i * 32'h0A3B + 7) & 32'h7FFF);
      simple(3'd2, t);
      expPc = t;
      check("R3 jump", fetchAddr, expPc);
      checkFetch();
      for (int s = 0; s < 3; s++) begin
        simple(3'd1, 15'h0);
        expPc = expPc + 15'd1;
        check("R2 step", fetchAddr, expPc);
        checkFetch();
      end
    end

    // ignored codes
    for (int c = 0; c < 8; c++) begin
      if (c == 0 || c == 6 || c == 7) begin
        simple(3'(c), 15'h2AAA);
        check("R8 bad code pc", fetchAddr, expPc);
        check("R8 bad code sp", spOut, expSp);
        check("R8 bad code busy", busy, 0);
      end
    end

    // nested calls with an interrupt inside, then unwind
    simple(3'd2, 15'h0100); expPc = 15'h0100;
    for (int n = 0; n < 6; n++) begin
      if (n == 3) doPush(1'b1, 15'h0, n[0]);
      else        doPush(1'b0, 15'((n * 32'h1357 + 32'h0240) & 32'h7FFF), n[0]);
      simple(3'd1, 15'h0); expPc = expPc + 15'd1;
      check("R2 step in call", fetchAddr, expPc);
    end
    for (int n = 0; n < 6; n++) doRet(n[0]);

    // empty-stack return then wrap
    check("R7 sp empty", spOut, 8'h6F);
    doRet(1'b0);
    check("R9 trap at top", trapHit, 1);
    simple(3'd1, 15'h0);
    expPc = 15'h0;
    check("R2 wrap after top", fetchAddr, expPc);

    // interrupt from top address, then return to it
    simple(3'd2, 15'h7FFF); expPc = 15'h7FFF;
    doPush(1'b1, 15'h0, 1'b1);
    doRet(1'b1);
    check("R5 return to top", fetchAddr, 15'h7FFF);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule